// File: doc/BRIEF.md
# Receive Sample Delay Tuning Sweep

This block searches for a usable receive sampling delay before a card link is run in a high-speed mode. It owns a 32-bit adjust register that carries a fixed-delay enable and a 6-bit delay field. On a start pulse it turns the fixed-delay enable on and tries delays one after another, beginning at zero. The trials stop one short of the clock divider value presented at start. For each trial it writes the delay field, asks an external command engine for a tuning-block read of the right length, and waits for that engine's pass/fail answer.

The first trial that passes ends the sweep. That delay stays in the register and success is reported. If every trial fails, the fixed-delay enable is turned off again and failure is reported. The register can be preloaded while the block is idle, so that bits outside the two fields it manages are kept through a sweep.

Top module: `rxd_delay_sweep`

## Requirements
- R1: After reset the adjust register reads 0 and busy, done, pass and cmd_req are all low.
- R2: A start accepted while idle with a nonzero divider sets bit 13 (fixed-delay enable) of the adjust register one clock later, before any request, and keeps every other bit.
- R3: Before each request the delay field, bits 21:16, holds the trial index. Trials run 0, 1, 2, … in ascending order.
- R4: cmd_len is 128 when bus_8bit was 1 at the accepted start and 64 otherwise. It does not change during the sweep.
- R5: On the first response with cmd_ok=1 the sweep stops, with no further request. done pulses for exactly one cycle with pass=1, and the register keeps bit 13 set with that trial's delay.
- R6: With divider D>0 and all responses failing, exactly D requests are made. Then bit 13 is cleared, the delay field is left at D-1, and done pulses with pass=0.
- R7: A start with divider 0 makes no request and leaves the register unchanged. done pulses on the next cycle with pass=0.
- R8: A start pulse while busy has no effect: the trial sequence, the request length and the outcome are unchanged.
- R9: adj_load replaces the whole register when the block is idle and start is low. It is ignored while busy.
- R10: While cmd_req is high and cmd_ack is low, cmd_req stays high and the register holds its value.
- R11: pass keeps its value after done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep (pulse) |
| clk_div | input | 6 | Current clock divider; bounds the trial count |
| bus_8bit | input | 1 | 1 when the data bus is 8 bits wide |
| adj_load | input | 1 | Preload the adjust register |
| adj_load_val | input | 32 | Value for preload |
| adj_value | output | 32 | Adjust register contents |
| cmd_req | output | 1 | Tuning read requested; held until cmd_ack |
| cmd_len | output | 8 | Tuning block length in bytes |
| cmd_ack | input | 1 | Command engine result valid (one cycle) |
| cmd_ok | input | 1 | Result of the tuning read, 1 = error-free |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| pass | output | 1 | Outcome of the last sweep |

## Verification
The hardest condition to reach from the ports is a start or preload that arrives in the same cycle as a command response in the middle of a sweep. At that moment the block is changing its trial index, and a wrongly gated start or load would corrupt the sequence or the preserved bits. The bench models the command engine with random response latency. In chosen sweeps it fires start (with the bus width flipped) and a preload of the inverted value exactly on the cycle of the second response. Random divider values and random pass positions, including positions beyond the divider, cover both outcomes. Directed sweeps cover dividers 0, 1 and 63.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SET  = 2'd1,
    ST_REQ  = 2'd2
  } sweep_st_t;
endpackage

// File: rtl/rxd_adjust_reg.sv
module rxd_adjust_reg #(
  parameter int DW      = 32,
  parameter int FIX_BIT = 13,
  parameter int DLY_LSB = 16,
  parameter int DLY_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [DW-1:0]    load_val,
  input  logic             fix_set,
  input  logic             fix_clr,
  input  logic             dly_wr,
  input  logic [DLY_W-1:0] dly_val,
  output logic [DW-1:0]    adj_o
);
  localparam int DLY_MSB = DLY_LSB + DLY_W - 1;
  localparam logic [DW-1:0] DLY_MASK = ((DW'(1) << DLY_W) - DW'(1)) << DLY_LSB;

  logic [DW-1:0] adj_q, adj_d;
  logic          adj_en;

  assign adj_en = load_en | fix_set | fix_clr | dly_wr;

  always_comb begin
    adj_d = adj_q;
    if (load_en) adj_d = load_val;
    if (fix_set) adj_d[FIX_BIT] = 1'b1;
    if (fix_clr) adj_d[FIX_BIT] = 1'b0;
    if (dly_wr)  adj_d[DLY_MSB:DLY_LSB] = dly_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      adj_q <= '0;
    else if (adj_en) adj_q <= adj_d;
  end

  assign adj_o = adj_q;

  // R3: a delay write touches only the delay field
  assert_dly_write_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_wr && !load_en && !fix_set && !fix_clr) |=>
      ((adj_q & ~DLY_MASK) == ($past(adj_q) & ~DLY_MASK)));

  // R2: fixed enable is on after a set
  assert_fix_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_set && !fix_clr && !load_en) |=> adj_q[FIX_BIT]);
endmodule

// File: rtl/rxd_len_sel.sv
module rxd_len_sel #(
  parameter int LEN_W      = 8,
  parameter int LEN_WIDE   = 128,
  parameter int LEN_NARROW = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             wide_i,
  output logic [LEN_W-1:0] len_o
);
  logic [LEN_W-1:0] len_q, len_d;

  assign len_d = wide_i ? LEN_W'(LEN_WIDE) : LEN_W'(LEN_NARROW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= LEN_W'(LEN_NARROW);
    else if (cap_en) len_q <= len_d;
  end

  assign len_o = len_q;

  // R4: only the two legal lengths ever appear
  assert_len_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q == LEN_W'(LEN_WIDE)) || (len_q == LEN_W'(LEN_NARROW)));
endmodule

// File: rtl/rxd_sweep_fsm.sv
module rxd_sweep_fsm
  import rxd_pkg::*;
#(
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DLY_W-1:0] div_i,
  input  logic             cmd_ack_i,
  input  logic             cmd_ok_i,
  output logic             busy_o,
  output logic             cmd_req_o,
  output logic             cap_o,
  output logic             fix_set_o,
  output logic             fix_clr_o,
  output logic             dly_wr_o,
  output logic [DLY_W-1:0] dly_o,
  output logic             done_o,
  output logic             pass_o
);
  localparam int CW = DLY_W + 1;

  sweep_st_t        st_q, st_d;
  logic [DLY_W-1:0] trial_q, trial_d, limit_q, limit_d;
  logic             done_q, done_d, pass_q, pass_d;
  logic             last_trial;

  assign last_trial = (CW'(trial_q) + CW'(1)) == CW'(limit_q);

  always_comb begin
    st_d      = st_q;
    trial_d   = trial_q;
    limit_d   = limit_q;
    done_d    = 1'b0;
    pass_d    = pass_q;
    cap_o     = 1'b0;
    fix_set_o = 1'b0;
    fix_clr_o = 1'b0;
    dly_wr_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          cap_o   = 1'b1;
          limit_d = div_i;
          pass_d  = 1'b0;
          trial_d = '0;
          if (div_i == '0) begin
            done_d = 1'b1;
          end else begin
            fix_set_o = 1'b1;
            st_d      = ST_SET;
          end
        end
      end
      ST_SET: begin
        dly_wr_o = 1'b1;
        st_d     = ST_REQ;
      end
      ST_REQ: begin
        if (cmd_ack_i) begin
          if (cmd_ok_i) begin
            pass_d = 1'b1;
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else if (last_trial) begin
            fix_clr_o = 1'b1;
            done_d    = 1'b1;
            st_d      = ST_IDLE;
          end else begin
            trial_d = trial_q + DLY_W'(1);
            st_d    = ST_SET;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      trial_q <= '0;
      limit_q <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (st_q != ST_REQ || cmd_ack_i) trial_q <= trial_d;
      if (cap_o) limit_q <= limit_d;
      if (cap_o || done_d) pass_q <= pass_d;
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign cmd_req_o = (st_q == ST_REQ);
  assign dly_o     = trial_q;
  assign done_o    = done_q;
  assign pass_o    = pass_q;

  // R5: done is a single-cycle pulse
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6: trial index stays below the captured divider during a sweep
  assert_trial_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (trial_q < limit_q));

  // R8: a start while busy leaves the captured bound alone
  assert_start_busy_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(limit_q));

  // R11: pass only moves at a start or at the end of a sweep
  assert_pass_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_d && !(start_i && !busy_o)) |=> $stable(pass_q));
endmodule

// File: rtl/rxd_delay_sweep.sv
module rxd_delay_sweep
  import rxd_pkg::*;
#(
  parameter int DW         = 32,
  parameter int FIX_BIT    = 13,
  parameter int DLY_LSB    = 16,
  parameter int DLY_W      = 6,
  parameter int LEN_W      = 8,
  parameter int LEN_WIDE   = 128,
  parameter int LEN_NARROW = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DLY_W-1:0] clk_div,
  input  logic             bus_8bit,
  input  logic             adj_load,
  input  logic [DW-1:0]    adj_load_val,
  output logic [DW-1:0]    adj_value,
  output logic             cmd_req,
  output logic [LEN_W-1:0] cmd_len,
  input  logic             cmd_ack,
  input  logic             cmd_ok,
  output logic             busy,
  output logic             done,
  output logic             pass
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             cap, fix_set, fix_clr, dly_wr, load_ok;
  logic [DLY_W-1:0] dly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign load_ok = adj_load & ~busy & ~start;

  rxd_sweep_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start),
    .div_i     (clk_div),
    .cmd_ack_i (cmd_ack),
    .cmd_ok_i  (cmd_ok),
    .busy_o    (busy),
    .cmd_req_o (cmd_req),
    .cap_o     (cap),
    .fix_set_o (fix_set),
    .fix_clr_o (fix_clr),
    .dly_wr_o  (dly_wr),
    .dly_o     (dly),
    .done_o    (done),
    .pass_o    (pass)
  );

  rxd_adjust_reg #(
    .DW(DW), .FIX_BIT(FIX_BIT), .DLY_LSB(DLY_LSB), .DLY_W(DLY_W)
  ) u_adj (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_en  (load_ok),
    .load_val (adj_load_val),
    .fix_set  (fix_set),
    .fix_clr  (fix_clr),
    .dly_wr   (dly_wr),
    .dly_val  (dly),
    .adj_o    (adj_value)
  );

  rxd_len_sel #(
    .LEN_W(LEN_W), .LEN_WIDE(LEN_WIDE), .LEN_NARROW(LEN_NARROW)
  ) u_len (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cap_en (cap),
    .wide_i (bus_8bit),
    .len_o  (cmd_len)
  );

  // R10: request and register hold until the engine answers
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_req && !cmd_ack) |=> (cmd_req && $stable(adj_value)));

  // R5: a passing sweep leaves the fixed enable on
  assert_pass_keeps_fix_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && pass) |-> adj_value[FIX_BIT]);

  // R9: preload is blocked during a sweep
  assert_load_blocked_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && adj_load && !cmd_req) |=> (adj_value != adj_load_val || $stable(adj_value)));
endmodule

// File: tb/rxd_delay_sweep_tb_top.sv
module rxd_delay_sweep_tb_top;
  localparam int FIX = 13;
  localparam logic [31:0] MASK = 32'h003F_2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  clk_div = '0;
  logic        bus_8bit = 1'b0;
  logic        adj_load = 1'b0;
  logic [31:0] adj_load_val = '0;
  logic [31:0] adj_value;
  logic        cmd_req;
  logic [7:0]  cmd_len;
  logic        cmd_ack = 1'b0;
  logic        cmd_ok = 1'b0;
  logic        busy, done, pass;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  rxd_delay_sweep dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .clk_div(clk_div),
    .bus_8bit(bus_8bit), .adj_load(adj_load), .adj_load_val(adj_load_val),
    .adj_value(adj_value), .cmd_req(cmd_req), .cmd_len(cmd_len),
    .cmd_ack(cmd_ack), .cmd_ok(cmd_ok), .busy(busy), .done(done), .pass(pass)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_final(input logic [31:0] init, input int div, input int pass_at);
    logic [31:0] o;
    o = init & ~MASK;
    if (div == 0) return init;
    if (pass_at < div) return o | (32'd1 << FIX) | (32'(pass_at) << 16);
    return o | (32'(div - 1) << 16);
  endfunction

  function automatic int exp_trials(input int div, input int pass_at);
    if (div == 0) return 0;
    return (pass_at < div) ? pass_at + 1 : div;
  endfunction

  task automatic run_case(input logic [31:0] init, input int div, input bit wide,
                          input int pass_at, input bit poke);
    int trials;
    bit fin;
    logic [31:0] held;
    @(negedge clk);
    adj_load = 1'b1; adj_load_val = init;
    @(negedge clk);
    adj_load = 1'b0;
    chk(adj_value == init, "R9 preload", adj_value, init);
    start = 1'b1; clk_div = 6'(div); bus_8bit = wide;
    @(negedge clk);
    start = 1'b0;
    if (div != 0) begin
      chk(adj_value == ((init & ~(32'd1 << FIX)) | (32'd1 << FIX)), "R2 fix set",
          adj_value, (init | (32'd1 << FIX)));
      chk(!cmd_req, "R2 no req yet", 32'(cmd_req), 0);
    end
    trials = 0; fin = 0;
    while (!fin) begin
      if (done) fin = 1;
      else if (trials > 64) begin
        chk(0, "R6 runaway", trials, 64); fin = 1;
      end else if (cmd_req) begin
        chk(adj_value[21:16] == 6'(trials), "R3 delay order", adj_value[21:16], trials);
        chk(cmd_len == (wide ? 8'd128 : 8'd64), "R4 length", cmd_len, wide ? 128 : 64);
        held = adj_value;
        repeat ($urandom_range(0, 2)) begin
          @(negedge clk);
          chk(cmd_req && adj_value == held, "R10 hold", adj_value, held);
        end
        cmd_ack = 1'b1; cmd_ok = (trials == pass_at);
        if (poke && trials == 1) begin
          start = 1'b1; bus_8bit = ~wide; clk_div = 6'd2;
          adj_load = 1'b1; adj_load_val = ~init;
        end
        @(negedge clk);
        cmd_ack = 1'b0; cmd_ok = 1'b0; start = 1'b0; adj_load = 1'b0;
        bus_8bit = wide; clk_div = 6'(div);
        trials++;
      end else @(negedge clk);
    end
    chk(trials == exp_trials(div, pass_at), poke ? "R8 trials busy-start" : "R6 trial count",
        trials, exp_trials(div, pass_at));
    chk(pass == (pass_at < div), div == 0 ? "R7 pass" : "R5 pass flag", pass, (pass_at < div));
    chk(adj_value == exp_final(init, div, pass_at), div == 0 ? "R7 reg" : "R6 final reg",
        adj_value, exp_final(init, div, pass_at));
    @(negedge clk);
    chk(!done && !busy, "R5 done pulse", {done, busy}, 0);
    repeat (2) @(negedge clk);
    chk(pass == (pass_at < div), "R11 pass held", pass, (pass_at < div));
    chk(!cmd_req, "R5 no extra req", cmd_req, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(adj_value == 0, "R1 reg", adj_value, 0);
    chk({busy, done, pass, cmd_req} == 4'b0, "R1 flags", {busy, done, pass, cmd_req}, 0);
    // directed corners
    run_case(32'hA5C0_1234, 0, 1'b0, 0, 1'b0);
    run_case(32'h0000_0000, 1, 1'b0, 0, 1'b0);
    run_case(32'hFFFF_FFFF, 1, 1'b1, 5, 1'b0);
    run_case(32'h1234_5678, 63, 1'b1, 62, 1'b0);
    run_case(32'h8000_0001, 63, 1'b0, 99, 1'b0);
    run_case(32'h0F0F_0F0F, 5, 1'b1, 3, 1'b1);
    run_case(32'hF0F0_F0F0, 4, 1'b0, 99, 1'b1);
    // random sweeps
    for (int i = 0; i < 30; i++) begin
      int d, p;
      d = $urandom_range(0, 63);
      p = $urandom_range(0, 70);
      run_case($urandom, d, 1'($urandom_range(0, 1)), p, 1'($urandom_range(0, 1)));
    end
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule